// File: doc/BRIEF.md
# Bus Device Search Sequencer

This block is the master-side controller that enumerates the 64-bit identifiers of every device on a single-wire, open-drain bus. It sits above a bit-level engine that can perform three operations: a bus reset that reports whether any device answered, a single-bit write, and a single-bit read. Bus timing belongs to that engine, not to this block. For each pass, the block issues the reset, sends the search command byte, and then runs 64 bit triplets. Each triplet is two reads followed by one write. Together the triplets walk one branch of the identifier tree.

A pass is started with a one-cycle `start` pulse. When `fresh` is high with that pulse, the enumeration restarts from the first device. Otherwise the pass continues from the branch point recorded by the previous successful pass. At the end of each pass the block delivers one identifier and a flag telling whether that identifier was the last one. If no device answers the reset, or if no device takes part in a triplet, the pass ends early with an error flag. CRC checking of the returned identifier is left to the consumer.

Top module: `ows_search`

## Requirements
- R1: After reset, `busy`, `pass_done`, `err`, `last_found` and `bl_req` are all 0.
- R2: A pass opens with a single reset operation (`bl_op` = 0). If the presence result (`bl_rbit` with that acknowledge) is 0, the pass ends with `err` = 1 and no further operation is requested.
- R3: After presence, the byte F0h is written as 8 write operations (`bl_op` = 1), least significant bit first.
- R4: The command is followed by exactly 64 triplets, handled from identifier bit 0 upward. Each triplet is a read (`bl_op` = 2) returning the true bit, then a read returning the complement, then a write of the chosen bit.
- R5: When the two reads differ, the written bit equals the first read value.
- R6: When both reads are 0 at 1-based position p, the written bit depends on the stored branch position L. If p < L, it is the bit of the previously returned identifier. If p = L, it is 1. If p > L, it is 0.
- R7: On a completed pass, `id_out` holds the 64 written bits (bit i = bit written in triplet i). L becomes the highest position where 0 was written after two 0 reads. `last_found` is 1 exactly when no such position exists.
- R8: When both reads of a triplet are 1, the pass ends at once with `err` = 1. `id_out` and L keep their values, so the next pass returns the identifier that would otherwise have followed.
- R9: `start` has no effect while `busy` is 1.
- R10: `start` with `fresh` = 1 clears L and `last_found`, so the pass returns the first identifier again.
- R11: `bl_req` is a one-cycle pulse, and no new request is made until the previous one has been acknowledged by `bl_ack`.
- R12: `pass_done` is a one-cycle pulse in the cycle after the acknowledge of the final operation of the pass. `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one search pass (ignored while busy) |
| fresh | input | 1 | With start: restart the enumeration from the first device |
| bl_req | output | 1 | One-cycle request to the bit-level engine |
| bl_op | output | 2 | Operation code: 0 reset, 1 write, 2 read |
| bl_wbit | output | 1 | Bit value for a write operation |
| bl_ack | input | 1 | Engine completion pulse |
| bl_rbit | input | 1 | Read result, or presence (1 = present) on a reset acknowledge |
| busy | output | 1 | A pass is in progress |
| pass_done | output | 1 | One-cycle end-of-pass pulse |
| err | output | 1 | Last pass ended without an identifier |
| last_found | output | 1 | Last identifier returned was the final one |
| id_out | output | 64 | Identifier found by the last successful pass |

## Verification
Each result of this block becomes visible exactly one clock after the engine acknowledge that completes a pass. This holds for `pass_done`, `err`, `id_out` and `last_found`, whether the pass ended after the reset, after a triplet with two 1 reads, or after the 64th write. The bench's bus model records the cycle number of every acknowledge it gives. It then samples the results on the falling edge and requires `pass_done` to appear exactly one cycle later. Requests are sampled on the falling edge in the cycle they are raised. Read data is returned the same way, with its acknowledge, so every comparison lands between edges.

// File: rtl/ows_pkg.sv
package ows_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } bl_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST,
        S_CMD,
        S_RDT,
        S_RDC,
        S_WR
    } seq_st_e;

    // Branch decision for one identifier bit
    typedef struct packed {
        logic dir;   // bit to write
        logic zero;  // 0 taken at a two-way branch
    } pick_t;

    localparam logic [7:0] SEARCH_CMD = 8'hF0;

endpackage

// File: rtl/ows_pick.sv
module ows_pick
    import ows_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic          t_bit,
    input  logic          c_bit,
    input  logic          prev_bit,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] last_disc,
    output pick_t         res
);

    always_comb begin
        res.dir  = t_bit;
        res.zero = 1'b0;
        if (!t_bit && !c_bit) begin
            if (pos < last_disc)
                res.dir = prev_bit;
            else if (pos == last_disc)
                res.dir = 1'b1;
            else
                res.dir = 1'b0;
            res.zero = !res.dir;
        end
    end

endmodule

// File: rtl/ows_track.sv
module ows_track
    import ows_pkg::*;
#(
    parameter int ID_W = 64,
    parameter int IW   = 6,
    parameter int PW   = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            begin_pass,
    input  logic            bit_we,
    input  logic            commit,
    input  logic [IW-1:0]   idx,
    input  logic [PW-1:0]   pos,
    input  pick_t           pk,
    output logic [ID_W-1:0] id_q,
    output logic [PW-1:0]   ld_q,
    output logic            last_found,
    output logic            prev_bit
);

    logic [ID_W-1:0] work, work_n;
    logic [PW-1:0]   lz, lz_n;

    always_comb begin
        work_n      = work;
        work_n[idx] = pk.dir;
        lz_n        = pk.zero ? pos : lz;
        prev_bit    = id_q[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work       <= '0;
            id_q       <= '0;
            ld_q       <= '0;
            lz         <= '0;
            last_found <= 1'b0;
        end else begin
            if (clear) begin
                ld_q       <= '0;
                last_found <= 1'b0;
            end
            if (begin_pass)
                lz <= '0;
            if (bit_we) begin
                work <= work_n;
                lz   <= lz_n;
                if (commit) begin
                    id_q       <= work_n;
                    ld_q       <= lz_n;
                    last_found <= (lz_n == '0);
                end
            end
        end
    end

endmodule

// File: rtl/ows_seq.sv
module ows_seq
    import ows_pkg::*;
#(
    parameter int ID_W = 64,
    parameter int IW   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          bl_ack,
    input  logic          bl_rbit,
    input  logic          dir,
    output logic          bl_req,
    output logic [1:0]    bl_op,
    output logic          bl_wbit,
    output logic          busy,
    output logic          pass_done,
    output logic          err,
    output logic          rd_t,
    output logic          rd_c,
    output logic [IW-1:0] idx,
    output logic          pass_begin,
    output logic          bit_we,
    output logic          commit
);

    seq_st_e       st;
    logic          issued;
    logic [IW-1:0] cnt;
    logic          fin, last_bit;

    always_comb begin
        busy       = (st != S_IDLE);
        bl_req     = busy && !issued;
        fin        = issued && bl_ack;
        last_bit   = (cnt == IW'(ID_W - 1));
        idx        = cnt;
        pass_begin = (st == S_IDLE) && start;
        bit_we     = fin && (st == S_WR);
        commit     = bit_we && last_bit;
        bl_wbit    = (st == S_CMD) ? SEARCH_CMD[cnt[2:0]] : dir;
        case (st)
            S_RST:        bl_op = OP_RESET;
            S_CMD, S_WR:  bl_op = OP_WRITE;
            default:      bl_op = OP_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            issued    <= 1'b0;
            cnt       <= '0;
            rd_t      <= 1'b0;
            rd_c      <= 1'b0;
            err       <= 1'b0;
            pass_done <= 1'b0;
        end else begin
            pass_done <= 1'b0;
            if (st == S_IDLE) begin
                if (start) begin
                    st     <= S_RST;
                    err    <= 1'b0;
                    issued <= 1'b0;
                end
            end else begin
                if (fin)
                    issued <= 1'b0;
                else if (bl_req)
                    issued <= 1'b1;
                if (fin) begin
                    case (st)
                        S_RST: begin
                            if (!bl_rbit) begin
                                err       <= 1'b1;
                                pass_done <= 1'b1;
                                st        <= S_IDLE;
                            end else begin
                                st  <= S_CMD;
                                cnt <= '0;
                            end
                        end
                        S_CMD: begin
                            if (cnt == IW'(7)) begin
                                st  <= S_RDT;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        S_RDT: begin
                            rd_t <= bl_rbit;
                            st   <= S_RDC;
                        end
                        S_RDC: begin
                            if (rd_t && bl_rbit) begin
                                err       <= 1'b1;
                                pass_done <= 1'b1;
                                st        <= S_IDLE;
                            end else begin
                                rd_c <= bl_rbit;
                                st   <= S_WR;
                            end
                        end
                        S_WR: begin
                            if (last_bit) begin
                                pass_done <= 1'b1;
                                st        <= S_IDLE;
                            end else begin
                                cnt <= cnt + 1'b1;
                                st  <= S_RDT;
                            end
                        end
                        default: st <= S_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ows_search.sv
module ows_search
    import ows_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            fresh,
    output logic            bl_req,
    output logic [1:0]      bl_op,
    output logic            bl_wbit,
    input  logic            bl_ack,
    input  logic            bl_rbit,
    output logic            busy,
    output logic            pass_done,
    output logic            err,
    output logic            last_found,
    output logic [ID_W-1:0] id_out
);

    localparam int IW = $clog2(ID_W);
    localparam int PW = $clog2(ID_W + 1);

    logic          rd_t, rd_c, pass_begin, bit_we, commit, prev_bit, clear;
    logic [IW-1:0] idx;
    logic [PW-1:0] pos, ld_q;
    pick_t         pk;

    assign pos   = PW'(idx) + PW'(1);
    assign clear = start && fresh && !busy;

    ows_seq #(.ID_W(ID_W), .IW(IW)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .bl_ack(bl_ack), .bl_rbit(bl_rbit), .dir(pk.dir),
        .bl_req(bl_req), .bl_op(bl_op), .bl_wbit(bl_wbit),
        .busy(busy), .pass_done(pass_done), .err(err),
        .rd_t(rd_t), .rd_c(rd_c), .idx(idx),
        .pass_begin(pass_begin), .bit_we(bit_we), .commit(commit)
    );

    ows_pick #(.PW(PW)) u_pick (
        .t_bit(rd_t), .c_bit(rd_c), .prev_bit(prev_bit),
        .pos(pos), .last_disc(ld_q), .res(pk)
    );

    ows_track #(.ID_W(ID_W), .IW(IW), .PW(PW)) u_track (
        .clk(clk), .rst(rst), .clear(clear), .begin_pass(pass_begin),
        .bit_we(bit_we), .commit(commit), .idx(idx), .pos(pos), .pk(pk),
        .id_q(id_out), .ld_q(ld_q), .last_found(last_found),
        .prev_bit(prev_bit)
    );

endmodule

// File: rtl/ows_search_chk.sv
module ows_search_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       fresh,
    input logic       bl_req,
    input logic [1:0] bl_op,
    input logic       bl_ack,
    input logic       busy,
    input logic       pass_done,
    input logic       err,
    input logic       last_found
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst)         pend <= 1'b0;
        else if (bl_ack) pend <= 1'b0;
        else if (bl_req) pend <= 1'b1;
    end

    p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        bl_req |=> !bl_req);

    p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
        bl_req |-> !pend);

    p_open_with_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (bl_req && bl_op == 2'd0));

    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        pass_done |-> !busy);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        pass_done |=> !pass_done);

    p_err_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> pass_done);

    p_fresh_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (start && fresh && !busy) |=> !last_found);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bl_req);

endmodule

bind ows_search ows_search_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .fresh(fresh),
    .bl_req(bl_req), .bl_op(bl_op), .bl_ack(bl_ack), .busy(busy),
    .pass_done(pass_done), .err(err), .last_found(last_found)
);

// File: tb/sim_ows_search.sv
module sim_ows_search;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst, start, fresh, bl_ack, bl_rbit;
    logic        bl_req, bl_wbit, busy, pass_done, err, last_found;
    logic [1:0]  bl_op;
    logic [63:0] id_out;

    int errors = 0, checks = 0, cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ows_search u0 (
        .clk(clk), .rst(rst), .start(start), .fresh(fresh),
        .bl_req(bl_req), .bl_op(bl_op), .bl_wbit(bl_wbit),
        .bl_ack(bl_ack), .bl_rbit(bl_rbit), .busy(busy),
        .pass_done(pass_done), .err(err), .last_found(last_found),
        .id_out(id_out)
    );

    // Bus model: devices, wired-AND reads, op-order tracking
    logic [63:0] dev_id [4];
    bit          active [4];
    int          n_dev = 0, ghost_at = -1;
    int          n_resets = 0, n_ops = 0, ord_err = 0, ovl = 0, ack_cyc = 0;
    int          phase = 0, cmd_cnt = 0, tp = 0, bi = 0;
    logic [7:0]  cmd_byte;
    logic [63:0] r_id;
    logic        r_err, r_lf;
    int          done_cyc;

    task automatic respond(input logic [1:0] op, input logic w, output logic rb);
        rb = 1'b1;
        n_ops++;
        if (op == 2'd0) begin
            n_resets++;
            for (int k = 0; k < 4; k++) active[k] = (k < n_dev);
            rb = (n_dev > 0);
            phase = 1; cmd_cnt = 0; tp = 0; bi = 0;
        end else if (op == 2'd1) begin
            if (phase == 1) begin
                cmd_byte[cmd_cnt] = w;
                cmd_cnt++;
                if (cmd_cnt == 8) phase = 2;
            end else if (phase == 2 && tp == 2) begin
                for (int k = 0; k < 4; k++)
                    if (active[k] && dev_id[k][bi] != w) active[k] = 1'b0;
                bi++; tp = 0;
            end else ord_err++;
        end else if (op == 2'd2 && phase == 2 && tp < 2) begin
            if (tp == 0 && bi == ghost_at)
                for (int k = 0; k < 4; k++) active[k] = 1'b0;
            for (int k = 0; k < 4; k++)
                if (active[k]) rb = rb & (tp == 0 ? dev_id[k][bi] : ~dev_id[k][bi]);
            tp++;
        end else ord_err++;
    endtask

    initial begin
        bit pend = 0;
        int wcnt = 0;
        logic [1:0] c_op;
        logic c_w, rb;
        bl_ack = 1'b0; bl_rbit = 1'b0;
        forever begin
            @(negedge clk);
            bl_ack = 1'b0;
            if (pend) begin
                if (bl_req) ovl++;
                if (wcnt == 0) begin
                    respond(c_op, c_w, rb);
                    bl_rbit = rb; bl_ack = 1'b1; pend = 0; ack_cyc = cyc;
                end else wcnt--;
            end else if (bl_req) begin
                pend = 1; c_op = bl_op; c_w = bl_wbit; wcnt = LAT;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rev(input logic [63:0] v);
        return {<<{v}};
    endfunction

    // Expected enumeration order: ascending bit-reversed identifier
    function automatic logic [63:0] nth_id(input int n);
        bit used [4];
        int best = 0;
        for (int k = 0; k < 4; k++) used[k] = 0;
        for (int j = 0; j <= n; j++) begin
            best = -1;
            for (int k = 0; k < n_dev; k++)
                if (!used[k] && (best < 0 || rev(dev_id[k]) < rev(dev_id[best]))) best = k;
            used[best] = 1;
        end
        return dev_id[best];
    endfunction

    task automatic run_pass(input logic f);
        ord_err = 0; n_ops = 0; n_resets = 0;
        @(negedge clk); start = 1'b1; fresh = f;
        @(negedge clk); start = 1'b0; fresh = 1'b0;
        while (!pass_done) @(negedge clk);
        done_cyc = cyc;
        r_id = id_out; r_err = err; r_lf = last_found;
        chk(done_cyc == ack_cyc + 1 && !busy, "R12 done one cycle after last ack", 64'(done_cyc - ack_cyc), 64'd1);
        @(negedge clk);
        chk(!pass_done, "R12 done is a pulse", 64'(pass_done), 64'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !pass_done && !err && !last_found && !bl_req, "R1 reset state",
            {59'd0, busy, pass_done, err, last_found, bl_req}, 64'd0);
    endtask

    task automatic t_absent;
        n_dev = 0;
        run_pass(1'b1);
        chk(r_err == 1'b1, "R2 no presence gives err", 64'(r_err), 64'd1);
        repeat (10) @(negedge clk);
        chk(n_ops == 1 && n_resets == 1, "R2 only the reset op issued", 64'(n_ops), 64'd1);
    endtask

    task automatic t_single;
        n_dev = 1; dev_id[0] = 64'h3C00_A5F0_1234_9E81;
        run_pass(1'b1);
        chk(cmd_byte == 8'hF0, "R3 command byte LSB first", 64'(cmd_byte), 64'hF0);
        chk(ord_err == 0 && n_ops == 201, "R4 op order and triplet count", 64'(n_ops + 1000 * ord_err), 64'd201);
        chk(r_id == dev_id[0] && !r_err, "R5 single device id", r_id, dev_id[0]);
        chk(r_lf == 1'b1, "R7 last_found with no branch", 64'(r_lf), 64'd1);
    endtask

    task automatic t_multi;
        n_dev = 3;
        dev_id[0] = 64'h8000_0000_0000_0001;
        dev_id[1] = 64'h0000_0000_0000_0003;
        dev_id[2] = 64'h8000_0000_4000_0001;
        for (int p = 0; p < 3; p++) begin
            run_pass(p == 0);
            chk(r_id == nth_id(p) && !r_err, "R6 enumeration order", r_id, nth_id(p));
            chk(r_lf == (p == 2), "R7 last_found only on final id", 64'(r_lf), 64'(p == 2));
        end
        run_pass(1'b0);
        chk(r_id == nth_id(0), "R7 wraps to first after last", r_id, nth_id(0));
    endtask

    task automatic t_ghost;
        logic [63:0] held;
        n_dev = 2;
        dev_id[0] = 64'h0123_4567_89AB_CDEF;
        dev_id[1] = 64'h0123_4567_89AB_CDEE;
        run_pass(1'b1);
        held = r_id;
        chk(r_id == nth_id(0), "R6 first of pair", r_id, nth_id(0));
        ghost_at = 20;
        run_pass(1'b0);
        chk(r_err == 1'b1, "R8 both reads 1 gives err", 64'(r_err), 64'd1);
        chk(r_id == held, "R8 id_out kept on err", r_id, held);
        chk(n_ops == 1 + 8 + 3 * 20 + 2, "R8 pass ends at the bad triplet", 64'(n_ops), 64'(71));
        ghost_at = -1;
        run_pass(1'b0);
        chk(r_id == nth_id(1) && !r_err, "R8 position kept across err", r_id, nth_id(1));
    endtask

    task automatic t_busy_start;
        n_dev = 1; dev_id[0] = 64'hFEDC_BA98_7654_3210;
        ord_err = 0; n_ops = 0; n_resets = 0;
        @(negedge clk); start = 1'b1; fresh = 1'b1;
        @(negedge clk); start = 1'b0; fresh = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; fresh = 1'b1;
        @(negedge clk); start = 1'b0; fresh = 1'b0;
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!pass_done) @(negedge clk);
        chk(id_out == dev_id[0] && ord_err == 0, "R9 pass unaffected by start", id_out, dev_id[0]);
        repeat (20) @(negedge clk);
        chk(n_resets == 1 && !busy, "R9 no second pass started", 64'(n_resets), 64'd1);
    endtask

    task automatic t_fresh;
        n_dev = 3;
        dev_id[0] = 64'h0000_0000_0000_00F0;
        dev_id[1] = 64'h0000_0000_0000_00F1;
        dev_id[2] = 64'h0000_0000_0000_00F2;
        run_pass(1'b1);
        run_pass(1'b0);
        chk(r_id == nth_id(1), "R10 second id before restart", r_id, nth_id(1));
        run_pass(1'b1);
        chk(r_id == nth_id(0) && !r_lf, "R10 fresh returns first id", r_id, nth_id(0));
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; fresh = 1'b0;
        for (int k = 0; k < 4; k++) begin dev_id[k] = '0; active[k] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_absent();
        t_single();
        t_multi();
        t_ghost();
        t_busy_start();
        t_fresh();
        chk(ovl == 0, "R11 no request while one is pending", 64'(ovl), 64'd0);
        summary();
        $finish;
    end

endmodule